// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Channel

This block moves an inbound byte stream into memory. Software builds a ring of two-word descriptors inside one 4 KiB page and advances a posted-pointer register. The channel then reads each descriptor's control word and buffer address, and writes the frame bytes into that buffer. It starts at a per-buffer byte offset taken from the control register. A frame longer than one buffer's usable capacity continues in the next descriptor. The end of a frame retires the current descriptor, so every frame starts in a fresh buffer.

Descriptors are never written back. Software learns of progress only from the current-descriptor field in the status word. Status also reports the channel state, an error code and the descriptor being worked on. Inbound bytes pass through a small FIFO, whose ready output throttles the source. When the channel stops on an error, it stays stopped until software clears the enable bit.

Top module: `rxdma_chan`

## Requirements
- R1: When control bit 0 (enable) is low or control bit 8 (direct FIFO mode) is high, the status word is all zero, no descriptor read or buffer write is issued, and in_ready is low.
- R2: Descriptor reads use the ring page from cfg_ring_base as address bits [31:12] and the current descriptor offset as bits [11:0]. The control word is at offset +0 and the buffer address word is at +4.
- R3: Byte k of a buffer's share of a frame is written at buffer address + offset + k, where offset is control bits [7:1]. Usable capacity is descriptor control bits [12:0] minus the offset. Bytes below the offset are not written.
- R4: A frame longer than one buffer's capacity continues at position 0 of the next descriptor's buffer.
- R5: The last byte of a frame retires the descriptor. The next frame starts in the following descriptor's buffer.
- R6: The current descriptor offset advances by 8 for each retired descriptor. It wraps to 0 after a descriptor whose control bit 28 (end of table) is set.
- R7: While the current offset equals cfg_last_ptr, the channel waits in state 2 and reads nothing. It resumes when cfg_last_ptr moves.
- R8: Status [11:0] holds the current offset. Status [15:12] holds the state: 0 off, 1 working, 2 waiting for descriptors, 3 stopped. Status [19:16] holds the error code. Status [31:20] holds the offset of the most recently fetched descriptor.
- R9: A descriptor whose size is not greater than the offset gives error 1 and stops the channel without any buffer write.
- R10: In state 2, with the FIFO full and in_valid high, the channel reports error 2 and stops.
- R11: A buffer write answered with wr_err gives error 3. A descriptor read answered with rd_err gives error 4. Both stop the channel.
- R12: A stopped channel issues no memory traffic and holds in_ready low. Clearing enable returns it to state 0 with error 0.
- R13: in_ready goes low once the FIFO holds FIFO_DEPTH unconsumed bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ctrl | input | 9 | bit 0 enable, bits [7:1] byte offset, bit 8 direct FIFO mode |
| cfg_ring_base | input | 20 | Ring page number (address bits [31:12]) |
| cfg_last_ptr | input | 12 | Offset one past the last posted descriptor |
| status | output | 32 | Current offset, state, error code, fetched descriptor |
| in_valid | input | 1 | Inbound byte present |
| in_data | input | 8 | Inbound byte |
| in_last | input | 1 | Byte ends its frame |
| in_ready | output | 1 | Channel accepts the byte |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 32 | Read data |
| rd_err | input | 1 | Read failed |
| wr_en | output | 1 | Buffer byte write |
| wr_addr | output | 32 | Buffer byte address |
| wr_data | output | 8 | Buffer byte |
| wr_err | input | 1 | Write failed, same cycle as wr_en |

## Verification
The main function is driven by a table of offset, buffer-size and frame-length combinations. The table covers a frame that fits inside one buffer, one that exactly fills it, and frames that spill across two and three buffers. This separates an off-by-one in the capacity rule from a wrong placement offset, and a missed spill from a missed retire. A ring of three descriptors is then walked to a wrap, frame by frame, so that waiting, resuming on a pointer update and the end-of-table wrap are seen separately. Each error source is provoked alone: a zero-capacity descriptor, a full FIFO with no descriptor, a failing write and a failing address-word read. This shows that each one yields its own code.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int PAGE_W     = 12;
    localparam int BC_W       = 13;
    localparam int OFF_W      = 7;
    localparam int DESC_BYTES = 8;
    localparam int EOT_BIT    = 28;

    typedef enum logic [3:0] {
        CH_OFF  = 4'd0,
        CH_BUSY = 4'd1,
        CH_WAIT = 4'd2,
        CH_HALT = 4'd3
    } ch_state_e;

    typedef enum logic [3:0] {
        E_NONE   = 4'd0,
        E_PROTO  = 4'd1,
        E_OVFL   = 4'd2,
        E_BUFWR  = 4'd3,
        E_DESCRD = 4'd4
    } ch_err_e;

    typedef enum logic [2:0] {
        F_OFF, F_WAIT, F_CTL, F_ADR, F_XFER, F_HALT
    } fsm_e;

    typedef struct packed {
        logic            eot;
        logic [BC_W-1:0] size;
    } dctl_t;

    typedef struct packed {
        logic       last;
        logic [7:0] data;
    } beat_t;

    function automatic dctl_t unpack_ctl(input logic [31:0] w);
        dctl_t r;
        r.eot  = w[EOT_BIT];
        r.size = w[BC_W-1:0];
        return r;
    endfunction

    function automatic logic [PAGE_W-1:0] step_slot(input logic [PAGE_W-1:0] cur,
                                                    input logic eot);
        return eot ? '0 : cur + PAGE_W'(DESC_BYTES);
    endfunction

    function automatic ch_state_e visible_state(input fsm_e f);
        case (f)
            F_OFF:   return CH_OFF;
            F_WAIT:  return CH_WAIT;
            F_HALT:  return CH_HALT;
            default: return CH_BUSY;
        endcase
    endfunction

    function automatic logic [31:0] make_status(input logic [PAGE_W-1:0] cur,
                                                input ch_state_e st,
                                                input ch_err_e err,
                                                input logic [PAGE_W-1:0] act);
        return {act, err, st, cur};
    endfunction

endpackage

// File: rtl/rxdma_fifo.sv
module rxdma_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = slots[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wp] <= din;
    end

endmodule

// File: rtl/rxdma_ring_ptr.sv
module rxdma_ring_ptr
    import rxdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              advance,
    input  logic              eot,
    input  logic              capture,
    output logic [PAGE_W-1:0] cur,
    output logic [PAGE_W-1:0] act
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur <= '0;
            act <= '0;
        end else begin
            if (advance) cur <= step_slot(cur, eot);
            if (capture) act <= cur;
        end
    end
endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [OFF_W-1:0]  offset,
    input  logic [19:0]       ring_base,
    input  logic [PAGE_W-1:0] last_ptr,
    input  logic [PAGE_W-1:0] cur,
    input  logic              in_valid,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  beat_t             fifo_beat,
    output logic              fifo_pop,
    output logic              rd_req,
    output logic [31:0]       rd_addr,
    input  logic              rd_ack,
    input  logic [31:0]       rd_data,
    input  logic              rd_err,
    output logic              wr_en,
    output logic [31:0]       wr_addr,
    output logic [7:0]        wr_data,
    input  logic              wr_err,
    output logic              advance,
    output logic              eot,
    output logic              capture,
    output logic              accepting,
    output ch_state_e         vis_state,
    output ch_err_e           err
);
    fsm_e            st, st_n;
    ch_err_e         err_n;
    dctl_t           dctl_q;
    logic [31:0]     bufa_q;
    logic [BC_W-1:0] fill_q;
    logic [BC_W-1:0] cap;
    logic            load_ctl, load_adr, fill_inc;

    assign cap       = dctl_q.size - BC_W'(offset);
    assign eot       = dctl_q.eot;
    assign vis_state = visible_state(st);
    assign accepting = (st != F_OFF) && (st != F_HALT);

    always_comb begin
        st_n     = st;
        err_n    = err;
        rd_req   = 1'b0;
        rd_addr  = {ring_base, cur};
        wr_en    = 1'b0;
        wr_addr  = bufa_q + 32'(offset) + 32'(fill_q);
        wr_data  = fifo_beat.data;
        fifo_pop = 1'b0;
        advance  = 1'b0;
        capture  = 1'b0;
        load_ctl = 1'b0;
        load_adr = 1'b0;
        fill_inc = 1'b0;
        if (!go) begin
            st_n  = F_OFF;
            err_n = E_NONE;
        end else begin
            case (st)
                F_OFF: st_n = F_WAIT;
                F_WAIT: begin
                    if (cur != last_ptr) begin
                        st_n    = F_CTL;
                        capture = 1'b1;
                    end else if (in_valid && fifo_full) begin
                        st_n  = F_HALT;
                        err_n = E_OVFL;
                    end
                end
                F_CTL: begin
                    rd_req = 1'b1;
                    if (rd_ack) begin
                        if (rd_err) begin
                            st_n  = F_HALT;
                            err_n = E_DESCRD;
                        end else begin
                            load_ctl = 1'b1;
                            st_n     = F_ADR;
                        end
                    end
                end
                F_ADR: begin
                    rd_req  = 1'b1;
                    rd_addr = {ring_base, cur + PAGE_W'(4)};
                    if (rd_ack) begin
                        if (rd_err) begin
                            st_n  = F_HALT;
                            err_n = E_DESCRD;
                        end else if (dctl_q.size <= BC_W'(offset)) begin
                            st_n  = F_HALT;
                            err_n = E_PROTO;
                        end else begin
                            load_adr = 1'b1;
                            st_n     = F_XFER;
                        end
                    end
                end
                F_XFER: begin
                    if (!fifo_empty) begin
                        wr_en    = 1'b1;
                        fifo_pop = 1'b1;
                        if (wr_err) begin
                            st_n  = F_HALT;
                            err_n = E_BUFWR;
                        end else begin
                            fill_inc = 1'b1;
                            if (fifo_beat.last || (fill_q + BC_W'(1) == cap)) begin
                                advance = 1'b1;
                                st_n    = F_WAIT;
                            end
                        end
                    end
                end
                default: st_n = F_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= F_OFF;
            err    <= E_NONE;
            dctl_q <= '0;
            bufa_q <= '0;
            fill_q <= '0;
        end else begin
            st  <= st_n;
            err <= err_n;
            if (load_ctl) dctl_q <= unpack_ctl(rd_data);
            if (load_adr) begin
                bufa_q <= rd_data;
                fill_q <= '0;
            end else if (fill_inc) begin
                fill_q <= fill_q + BC_W'(1);
            end
        end
    end
endmodule

// File: rtl/rxdma_chan.sv
module rxdma_chan
    import rxdma_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [8:0]  cfg_ctrl,
    input  logic [19:0] cfg_ring_base,
    input  logic [11:0] cfg_last_ptr,
    output logic [31:0] status,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    output logic        rd_req,
    output logic [31:0] rd_addr,
    input  logic        rd_ack,
    input  logic [31:0] rd_data,
    input  logic        rd_err,
    output logic        wr_en,
    output logic [31:0] wr_addr,
    output logic [7:0]  wr_data,
    input  logic        wr_err
);
    localparam int BEAT_W = $bits(beat_t);

    logic              go, accepting, fifo_full, fifo_empty, fifo_pop;
    logic              advance, eot, capture;
    logic [PAGE_W-1:0] cur, act;
    beat_t             in_beat, fifo_beat;
    ch_state_e         vis_state;
    ch_err_e           err;

    assign go       = cfg_ctrl[0] && !cfg_ctrl[8];
    assign in_beat  = '{last: in_last, data: in_data};
    assign in_ready = go && accepting && !fifo_full;
    assign status   = make_status(cur, vis_state, err, act);

    rxdma_fifo #(.DEPTH(FIFO_DEPTH), .W(BEAT_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (!go),
        .push  (in_valid && in_ready),
        .din   (in_beat),
        .pop   (fifo_pop),
        .dout  (fifo_beat),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    rxdma_ring_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .clear   (!go),
        .advance (advance),
        .eot     (eot),
        .capture (capture),
        .cur     (cur),
        .act     (act)
    );

    rxdma_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .offset     (cfg_ctrl[7:1]),
        .ring_base  (cfg_ring_base),
        .last_ptr   (cfg_last_ptr),
        .cur        (cur),
        .in_valid   (in_valid),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .fifo_beat  (fifo_beat),
        .fifo_pop   (fifo_pop),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .rd_err     (rd_err),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_err     (wr_err),
        .advance    (advance),
        .eot        (eot),
        .capture    (capture),
        .accepting  (accepting),
        .vis_state  (vis_state),
        .err        (err)
    );
endmodule

// File: rtl/rxdma_chan_chk.sv
module rxdma_chan_chk (
    input logic        clk,
    input logic        rst,
    input logic [8:0]  cfg_ctrl,
    input logic [19:0] cfg_ring_base,
    input logic [31:0] status,
    input logic        in_ready,
    input logic        rd_req,
    input logic [31:0] rd_addr,
    input logic        wr_en
);
    // R1
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (status[15:12] == 4'd0) |-> (!rd_req && !wr_en && !in_ready && status[19:16] == 4'd0));

    // R12
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (status[15:12] == 4'd3) |-> (!rd_req && !wr_en && !in_ready));

    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (status[11:0] != $past(status[11:0])) |->
        (status[11:0] == $past(status[11:0]) + 12'd8 || status[11:0] == 12'd0));

    // R2
    ring_page_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[31:12] == cfg_ring_base && rd_addr[1:0] == 2'b00));

    // R8
    err_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (status[19:16] != 4'd0) |-> (status[15:12] == 4'd3));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (status[19:16] == 4'd2) |=> (status[15:12] == 4'd3 || !cfg_ctrl[0]));
endmodule

bind rxdma_chan rxdma_chan_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_ctrl      (cfg_ctrl),
    .cfg_ring_base (cfg_ring_base),
    .status        (status),
    .in_ready      (in_ready),
    .rd_req        (rd_req),
    .rd_addr       (rd_addr),
    .wr_en         (wr_en)
);

// File: tb/tb_rxdma_chan.sv
module tb_rxdma_chan;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [8:0]  cfg_ctrl = '0;
    logic [19:0] cfg_ring_base = 20'h00001;
    logic [11:0] cfg_last_ptr = '0;
    logic [31:0] status;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        rd_req, rd_ack, rd_err;
    logic [31:0] rd_addr, rd_data;
    logic        wr_en, wr_err;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;

    logic [31:0] ring_w [32];
    logic [7:0]  buf_mem [4096];
    logic        clr = 1'b0;
    logic [31:0] bad_rd = 32'hFFFF_FFFF;
    logic [31:0] bad_wr = 32'hFFFF_FFFF;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic        bad_page = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    rxdma_chan dut (.*);

    assign rd_ack  = rd_req;
    assign rd_data = ring_w[rd_addr[6:2]];
    assign rd_err  = rd_req && (rd_addr == bad_rd);
    assign wr_err  = wr_en && (wr_addr == bad_wr);

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 4096; i++) buf_mem[i] <= 8'hEE;
        end else if (wr_en && !wr_err) begin
            buf_mem[wr_addr[11:0]] <= wr_data;
        end
        if (wr_en) wr_cnt <= wr_cnt + 1;
        if (rd_req && rd_ack) begin
            rd_cnt <= rd_cnt + 1;
            if (rd_addr[31:12] != cfg_ring_base) bad_page <= 1'b1;
        end
    end

    // {offset, buffer size, frame length, expected current offset}
    localparam logic [31:0] VEC [4] = '{
        {8'd0,  8'd16, 8'd5,  8'd8},
        {8'd4,  8'd12, 8'd8,  8'd8},
        {8'd2,  8'd8,  8'd13, 8'd24},
        {8'd10, 8'd20, 8'd11, 8'd16}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int k);
        return 8'(seed * 37 + k * 5 + 1);
    endfunction

    task automatic build_ring(input int n, input int bsz, input int eot_idx);
        for (int i = 0; i < 16; i++) begin
            ring_w[2*i]   = 32'(bsz) | ((i == eot_idx) ? 32'h1000_0000 : 32'h0);
            ring_w[2*i+1] = 32'h100 * 32'(i + 1);
        end
        if (n < 0) ring_w[0] = 32'h0;
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic send_frame(input int len, input int seed);
        for (int k = 0; k < len; k++) push(bval(seed, k), k == len - 1);
    endtask

    task automatic fresh(input logic [8:0] ctrl, input logic [11:0] last);
        cfg_ctrl = '0;
        repeat (2) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        cfg_last_ptr = last;
        cfg_ctrl = ctrl;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int snap;
        build_ring(4, 8, 3);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset status", status, 32'h0);
        chk("R1 reset in_ready", 32'(in_ready), 32'h0);

        // Table walk: R3, R4, R5
        for (int v = 0; v < 4; v++) begin
            int off, bsz, len, ecur, cap;
            off  = int'(VEC[v][31:24]);
            bsz  = int'(VEC[v][23:16]);
            len  = int'(VEC[v][15:8]);
            ecur = int'(VEC[v][7:0]);
            cap  = bsz - off;
            build_ring(4, bsz, 3);
            fresh({1'b0, 7'(off), 1'b1}, 12'd24);
            send_frame(len, v);
            repeat (30) @(negedge clk);
            for (int k = 0; k < len; k++)
                chk("R3 R4 data", 32'(buf_mem[32'h100 * 32'(k / cap + 1) + 32'(off + k % cap)]),
                    32'(bval(v, k)));
            if (off > 0) chk("R3 below offset", 32'(buf_mem[32'h100 + 32'(off - 1)]), 32'hEE);
            chk("R5 R8 current offset", 32'(status[11:0]), 32'(ecur));
            chk("R7 R8 state", 32'(status[15:12]), (ecur == 24) ? 32'd2 : 32'd1);
            chk("R8 error", 32'(status[19:16]), 32'd0);
        end
        chk("R2 ring page", 32'(bad_page), 32'd0);

        // Wrap walk: R5, R6, R7, R8
        build_ring(3, 8, 2);
        fresh(9'h001, 12'd16);
        send_frame(8, 10);
        repeat (20) @(negedge clk);
        chk("R8 current after first", 32'(status[11:0]), 32'd8);
        chk("R8 fetched descriptor", 32'(status[31:20]), 32'd8);
        chk("R8 working state", 32'(status[15:12]), 32'd1);
        send_frame(3, 11);
        repeat (20) @(negedge clk);
        chk("R7 waiting state", 32'(status[15:12]), 32'd2);
        chk("R5 next buffer", 32'(buf_mem[12'h200]), 32'(bval(11, 0)));
        snap = rd_cnt;
        repeat (10) @(negedge clk);
        chk("R7 no reads while waiting", 32'(rd_cnt), 32'(snap));
        cfg_last_ptr = 12'd0;
        repeat (10) @(negedge clk);
        chk("R7 resumed", 32'(status[15:12]), 32'd1);
        send_frame(2, 12);
        repeat (20) @(negedge clk);
        chk("R6 wrap to zero", 32'(status[11:0]), 32'd0);
        chk("R6 wrap idle", 32'(status[15:12]), 32'd2);
        chk("R6 third buffer", 32'(buf_mem[12'h301]), 32'(bval(12, 1)));

        // R9: size not above offset
        build_ring(3, 8, 2);
        fresh({1'b0, 7'd8, 1'b1}, 12'd8);
        snap = wr_cnt;
        repeat (10) @(negedge clk);
        chk("R9 status", status, {12'h000, 4'h1, 4'h3, 12'h000});
        chk("R9 no write", 32'(wr_cnt), 32'(snap));
        chk("R12 ready low when stopped", 32'(in_ready), 32'd0);
        cfg_ctrl = '0;
        repeat (2) @(negedge clk);
        chk("R12 cleared by disable", status, 32'h0);

        // R10, R13: no descriptors, FIFO fills
        fresh(9'h001, 12'd0);
        for (int k = 0; k < 4; k++) push(8'(k), 1'b0);
        chk("R13 ready low when full", 32'(in_ready), 32'd0);
        chk("R7 waiting with no descriptor", 32'(status[15:12]), 32'd2);
        in_valid = 1'b1;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        chk("R10 overflow status", status[19:12], 8'h23);

        // R11: buffer write error
        build_ring(3, 8, 2);
        bad_wr = 32'h102;
        fresh({1'b0, 7'd2, 1'b1}, 12'd8);
        push(8'h5A, 1'b1);
        repeat (10) @(negedge clk);
        chk("R11 write error", status[19:12], 8'h33);
        bad_wr = 32'hFFFF_FFFF;

        // R11: descriptor read error on address word
        bad_rd = 32'h1004;
        fresh(9'h001, 12'd8);
        repeat (10) @(negedge clk);
        chk("R11 read error", status, 32'h0004_3000);
        bad_rd = 32'hFFFF_FFFF;

        // R1: direct FIFO mode bypasses the engine
        fresh(9'h101, 12'd8);
        snap = rd_cnt;
        repeat (10) @(negedge clk);
        chk("R1 bypass status", status, 32'h0);
        chk("R1 bypass no reads", 32'(rd_cnt), 32'(snap));
        chk("R1 bypass ready", 32'(in_ready), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule